// File: doc/BRIEF.md
# Multi-Dimensional Element Index Remapper

This block turns a plain loop step into an element index that walks a one-, two- or three-dimensional array in a chosen order. A 32-bit shape word sets the size of each of the three dimensions, a small base offset, and a permute code. The permute code picks which dimension moves fastest, which gives transposed traversal of matrices and volumes without any change to the loop that drives the block.

The user pulses `start` to begin a new traversal, then pulses `step` once per element. Three internal counters advance like an odometer whose digit order comes from the permute code. The output index is always computed with the x counter as the unit stride, y scaled by the x extent and z scaled by the x·y plane size, plus the offset. A shape word of all zeros turns remapping off, and the output then simply counts steps.

Top module: `idx_remapper`

## Requirements
- R1: After reset, and in the cycle after `start` is sampled high, all three counters and the linear step count are zero, so `idxOut` equals the offset (or 0 when the shape word is all zeros). `start` takes priority over `step` in the same cycle.
- R2: Shape word fields: x size-minus-one in bits [6:0], y size-minus-one in [14:8], z size-minus-one in [22:16], offset bits 0, 1 and 2 at bit positions 7, 15 and 23, permute code in [26:24]; bits [31:27] are ignored. A size field of 0 means a dimension of one element.
- R3: When the shape word is all zeros, `idxOut` equals the number of `step` pulses since the last `start`, modulo 2^22.
- R4: With remapping active, `idxOut` = offset + cx + cy·X + cz·X·Y, where cx, cy, cz are the counter values and X, Y are the real sizes (field value plus one).
- R5: Permute code sets the digit order, fastest first: 0 = x,y,z; 1 = x,z,y; 2 = y,x,z; 3 = y,z,x; 4 = z,x,y; 5 = z,y,x.
- R6: On each `step` the fastest counter increments; a counter at its last value (size minus one) wraps to zero and carries one into the next counter in the order.
- R7: After X·Y·Z steps from `start`, all counters are back at zero and `idxOut` again equals the offset.
- R8: Permute codes 6 and 7 are reserved: `reservedErr` is 1, `idxOut` is 0, and `step` pulses are ignored so the counters hold; restoring a valid code brings back the index they held.
- R9: A step sampled at a rising edge shows in `idxOut` right after that edge; without `start` or `step` the index is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| shapeWord | input | 32 | Dimension sizes, offset bits and permute code |
| start | input | 1 | Clear all counters to begin a traversal |
| step | input | 1 | Advance to the next element |
| idxOut | output | 22 | Remapped element index |
| reservedErr | output | 1 | High while the permute code is reserved |

## Verification
A wrong counter or a wrong carry decision shows at `idxOut` in the very cycle after the faulty step, because the index is a direct function of the counter registers; a bad digit order shows as a stride of 1 where X was expected (or the reverse) on the first step of a transposed shape. Counter errors that cancel within one dimension still surface at the next wrap, when the index fails to return to the offset after X·Y·Z steps. The bench models the odometer itself and compares every cycle under random shapes, orders and step patterns.

// File: rtl/remap_pkg.sv
package remap_pkg;

  localparam int NUM_DIMS = 3;

  typedef struct packed {
    logic       start;    // clear everything
    logic       advance;  // one element step accepted
    logic [2:0] inc;      // per-dimension increment
    logic [2:0] clr;      // per-dimension wrap to zero
  } remapStrobes_t;

  // Returns {slowest, middle, fastest} dimension numbers, two bits each.
  function automatic logic [5:0] permOrder(input logic [2:0] code);
    logic [5:0] ord;
    case (code)
      3'd0:    ord = {2'd2, 2'd1, 2'd0};
      3'd1:    ord = {2'd1, 2'd2, 2'd0};
      3'd2:    ord = {2'd2, 2'd0, 2'd1};
      3'd3:    ord = {2'd0, 2'd2, 2'd1};
      3'd4:    ord = {2'd1, 2'd0, 2'd2};
      3'd5:    ord = {2'd0, 2'd1, 2'd2};
      default: ord = {2'd2, 2'd1, 2'd0};
    endcase
    return ord;
  endfunction

endpackage

// File: rtl/remap_ctrl.sv
module remap_ctrl
  import remap_pkg::*;
#(
  parameter int PERMW = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic                step,
  input  logic [PERMW-1:0]    permCode,
  input  logic [2:0]          atLast,
  output remapStrobes_t       strb,
  output logic                reserved
);

  localparam int LAST_CODE = 5;

  logic [5:0] order;
  logic [1:0] dFast, dMid, dSlow;

  assign reserved = (int'(permCode) > LAST_CODE);
  assign order    = permOrder(permCode[2:0]);
  assign dFast    = order[1:0];
  assign dMid     = order[3:2];
  assign dSlow    = order[5:4];

  always_comb begin
    strb       = '0;
    strb.start = start;
    if (!start && step && !reserved) begin
      strb.advance   = 1'b1;
      strb.inc[dFast] = 1'b1;
      if (atLast[dFast]) begin
        strb.clr[dFast] = 1'b1;
        strb.inc[dMid]  = 1'b1;
        if (atLast[dMid]) begin
          strb.clr[dMid]  = 1'b1;
          strb.inc[dSlow] = 1'b1;
          if (atLast[dSlow]) strb.clr[dSlow] = 1'b1;
        end
      end
    end
  end

  AST_SINGLE_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.inc & ~strb.clr)) else $error("carry chain raised two counters"); // R6

  AST_RESERVED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (step && !start && int'(permCode) > LAST_CODE) |-> (strb.inc == 3'b000)) else $error("reserved code advanced"); // R8

endmodule

// File: rtl/remap_dp.sv
module remap_dp
  import remap_pkg::*;
#(
  parameter int DIMW  = 7,
  parameter int WORDW = 32,
  parameter int IDXW  = 3 * DIMW + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  remapStrobes_t       strb,
  input  logic [WORDW-1:0]    shapeWord,
  input  logic                reserved,
  output logic [2:0]          atLast,
  output logic [IDXW-1:0]     idxOut
);

  localparam int FLDW = DIMW + 1;

  logic [NUM_DIMS-1:0][DIMW-1:0] lim;
  logic [NUM_DIMS-1:0][DIMW-1:0] cnt;
  logic [NUM_DIMS-1:0]           offsBits;
  logic [NUM_DIMS-1:0][IDXW-1:0] extent;
  logic [IDXW-1:0]               linCnt;
  logic [IDXW-1:0]               strideY, strideZ, idxRemap;
  logic                          disabled;

  for (genvar k = 0; k < NUM_DIMS; k++) begin : g_field
    assign lim[k]      = shapeWord[k*FLDW +: DIMW];
    assign offsBits[k] = shapeWord[k*FLDW + DIMW];
    assign extent[k]   = IDXW'(lim[k]) + IDXW'(1);
    assign atLast[k]   = (cnt[k] >= lim[k]);
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.start) begin
      cnt    <= '0;
      linCnt <= '0;
    end else begin
      for (int k = 0; k < NUM_DIMS; k++) begin
        if (strb.clr[k])      cnt[k] <= '0;
        else if (strb.inc[k]) cnt[k] <= cnt[k] + DIMW'(1);
      end
      if (strb.advance) linCnt <= linCnt + IDXW'(1);
    end
  end

  assign disabled = (shapeWord == '0);
  assign strideY  = extent[0];
  assign strideZ  = extent[0] * extent[1];

  always_comb begin
    idxRemap = IDXW'(offsBits) + IDXW'(cnt[0]) + IDXW'(cnt[1]) * strideY
             + IDXW'(cnt[2]) * strideZ;
    if (reserved)      idxOut = '0;
    else if (disabled) idxOut = linCnt;
    else               idxOut = idxRemap;
  end

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> (cnt == '0 && linCnt == '0)) else $error("start did not clear"); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.start && !strb.advance) |=> ($stable(cnt) && $stable(linCnt))) else $error("state moved without step"); // R9

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.start) |=> (linCnt == $past(linCnt) + IDXW'(1))) else $error("linear count skipped"); // R3

endmodule

// File: rtl/idx_remapper.sv
module idx_remapper
  import remap_pkg::*;
#(
  parameter int DIMW  = 7,
  parameter int WORDW = 32,
  parameter int PERMW = 3,
  parameter int IDXW  = 3 * DIMW + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORDW-1:0]   shapeWord,
  input  logic               start,
  input  logic               step,
  output logic [IDXW-1:0]    idxOut,
  output logic               reservedErr
);

  localparam int PERM_LSB = NUM_DIMS * (DIMW + 1);

  remapStrobes_t strb;
  logic [2:0]    atLast;
  logic          reserved;

  remap_ctrl #(.PERMW(PERMW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .step     (step),
    .permCode (shapeWord[PERM_LSB +: PERMW]),
    .atLast   (atLast),
    .strb     (strb),
    .reserved (reserved)
  );

  remap_dp #(.DIMW(DIMW), .WORDW(WORDW), .IDXW(IDXW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .shapeWord (shapeWord),
    .reserved  (reserved),
    .atLast    (atLast),
    .idxOut    (idxOut)
  );

  assign reservedErr = reserved;

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    reservedErr |-> (idxOut == '0)) else $error("reserved code gave nonzero index"); // R8

endmodule

// File: tb/idx_remapper_test.sv
module idx_remapper_test;

  logic        clk = 1'b0;
  logic        rstN, start, step;
  logic [31:0] shape;
  logic [21:0] idxOut;
  logic        reservedErr;
  int          nChk = 0, nFail = 0;
  int          mc[3];
  int          lin;

  always #10 clk = ~clk;

  idx_remapper uut (
    .clk(clk), .rstN(rstN), .shapeWord(shape), .start(start), .step(step),
    .idxOut(idxOut), .reservedErr(reservedErr)
  );

  function automatic logic [31:0] mkShape(int xs, int ys, int zs, int offs, int perm);
    logic [2:0] o;
    o = offs[2:0];
    return {5'b0, perm[2:0], o[2], zs[6:0], o[1], ys[6:0], o[0], xs[6:0]};
  endfunction

  function automatic logic [21:0] expIdx(logic [31:0] s);
    int x, y, ofs;
    if (s[26:24] > 3'd5) return '0;
    if (s == '0) return lin[21:0];
    x   = int'(s[6:0]) + 1;
    y   = int'(s[14:8]) + 1;
    ofs = int'({s[23], s[15], s[7]});
    return 22'(ofs + mc[0] + mc[1] * x + mc[2] * x * y);
  endfunction

  task automatic modelStep();
    int ord[3];
    int lim[3];
    if (shape[26:24] > 3'd5) return;
    lin++;
    lim[0] = int'(shape[6:0]); lim[1] = int'(shape[14:8]); lim[2] = int'(shape[22:16]);
    case (shape[26:24])
      3'd0: ord = '{0, 1, 2};
      3'd1: ord = '{0, 2, 1};
      3'd2: ord = '{1, 0, 2};
      3'd3: ord = '{1, 2, 0};
      3'd4: ord = '{2, 0, 1};
      default: ord = '{2, 1, 0};
    endcase
    for (int i = 0; i < 3; i++) begin
      if (mc[ord[i]] >= lim[ord[i]]) mc[ord[i]] = 0;
      else begin mc[ord[i]]++; break; end
    end
  endtask

  task automatic check(string req, logic [21:0] got, logic [21:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic checkNow(string req);
    check(req, idxOut, expIdx(shape));
    check({req, " err"}, 22'(reservedErr), 22'(shape[26:24] > 3'd5));
  endtask

  task automatic cyc(logic st, logic sp, string req);
    start = st; step = sp;
    @(posedge clk);
    if (st) begin mc = '{0, 0, 0}; lin = 0; end
    else if (sp) modelStep();
    @(negedge clk);
    start = 0; step = 0;
    checkNow(req);
  endtask

  initial begin
    #(20 * 200000);
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    logic [21:0] held;
    void'($urandom(32'd1234));
    rstN = 0; start = 0; step = 0; shape = '0;
    mc = '{0, 0, 0}; lin = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    checkNow("R1 reset");

    // R3: all-zero shape counts steps linearly
    cyc(1, 0, "R3 start");
    for (int i = 0; i < 5; i++) cyc(0, 1, "R3 linear");
    check("R3 five steps", idxOut, 22'd5);

    // R2/R4/R6: 4x3x2, offset 5, x fastest
    shape = mkShape(3, 2, 1, 5, 0);
    cyc(1, 1, "R1 start priority");
    check("R1 offset after start", idxOut, 22'd5);
    for (int i = 0; i < 3; i++) cyc(0, 1, "R4 x run");
    check("R4 x at last", idxOut, 22'd8);
    cyc(0, 1, "R6 carry");
    check("R6 carry into y", idxOut, 22'd9);
    cyc(0, 0, "R9 idle");
    check("R9 stable", idxOut, 22'd9);

    // R7: full wrap after X*Y*Z steps
    cyc(1, 0, "R7 start");
    for (int i = 0; i < 24; i++) cyc(0, 1, "R7 walk");
    check("R7 wrap to offset", idxOut, 22'd5);

    // R5: transposed order, y fastest
    shape = mkShape(3, 2, 0, 0, 2);
    cyc(1, 0, "R5 start");
    cyc(0, 1, "R5 first step");
    check("R5 y stride", idxOut, 22'd4);
    cyc(0, 1, "R5 y step");
    cyc(0, 1, "R5 y carry");
    check("R5 carry into x", idxOut, 22'd1);

    // R8: reserved code holds counters
    held = idxOut;
    shape = mkShape(3, 2, 0, 0, 6);
    cyc(0, 1, "R8 reserved step");
    check("R8 zero index", idxOut, 22'd0);
    check("R8 flag", 22'(reservedErr), 22'd1);
    shape = mkShape(3, 2, 0, 0, 2);
    cyc(0, 0, "R8 restore");
    check("R8 held index", idxOut, held);

    // Random mix, every cycle compared with the model (R4 R5 R6)
    for (int t = 0; t < 300; t++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) shape = '0;
      else shape = mkShape(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
                           int'($urandom_range(0, 3)), int'($urandom_range(0, 7)),
                           (r == 9) ? int'($urandom_range(6, 7)) : int'($urandom_range(0, 5)));
      cyc(1, 0, "R1 random start");
      for (int c = 0; c < 40; c++)
        cyc(($urandom_range(0, 39) == 0), ($urandom_range(0, 3) != 0), "R4 random");
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule